// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

This block holds one BCD digit (0 to 9) and steps it up or down on the rising edges of two separate strobe inputs, one per direction. Both strobes are sampled by a single system clock through a short synchroniser chain, and a count step fires when the synchronised strobe shows a 0-to-1 transition while the opposite strobe is idle high. A clear input and an active-low load input act on the digit output without waiting for a clock edge, with clear taking priority over load and load over counting.

Two active-low terminal-count outputs announce overflow and underflow. The overflow output goes low while the digit shows bits 0 and 3 set and the up strobe is low; the underflow output goes low while the digit is zero and the down strobe is low. Each returns high as the strobe rises, so connecting them to the up and down strobes of a second instance builds a multi-digit counter. Codes 10 to 15, reachable only by loading, follow a fixed self-correcting path back into the decimal range.

Top module: `decade_updn_counter`

## Requirements
- R1: While `clear_i` is 1 the digit output is 0 at once, regardless of `load_n_i`, `data_i` and the strobes, and the stored count is 0 after the next clock edge.
- R2: While `load_n_i` is 0 and `clear_i` is 0, `q_o` equals `data_i` without waiting for a clock edge, the stored count takes `data_i` on each clock edge, and strobe edges have no effect.
- R3: With clear 0 and load 1, a rising edge on `up_i` while `dn_i` is high adds one to the digit (9 wraps to 0); with two synchroniser stages the new value is visible after the third system clock edge following the rise.
- R4: With clear 0 and load 1, a rising edge on `dn_i` while `up_i` is high subtracts one from the digit (0 wraps to 9), with the same latency as R3.
- R5: Counting up from the codes above 9 follows 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15 and 15 to 2.
- R6: Counting down from the codes above 9 steps 15, 14, 13, 12, 11, 10 and then 9.
- R7: The digit holds when rising edges on both strobes are detected in the same system cycle, and when a strobe rises while the other strobe is low.
- R8: `tc_up_n_o` is 0 exactly while bits 0 and 3 of `q_o` are both 1 and the synchronised up strobe is low, so at count 9 it stays low for as many system cycles as the up strobe was held low.
- R9: `tc_dn_n_o` is 0 exactly while all four bits of `q_o` are 0 and the synchronised down strobe is low.
- R10: With one instance's `tc_up_n_o` and `tc_dn_n_o` driving the `up_i` and `dn_i` of a second instance, the pair counts 00 to 99 with carry on 9 to 0 and borrow on 0 to 9.
- R11: While `rst_n` is 0 at a clock edge, the stored count becomes 0 and both synchronisers take the idle-high state, so a strobe that is high when reset is released causes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Clear to zero, active high, highest priority |
| load_n_i | input | 1 | Parallel load, active low |
| data_i | input | 4 | Value to load |
| up_i | input | 1 | Up-count strobe, counts on its rising edge |
| dn_i | input | 1 | Down-count strobe, counts on its rising edge |
| q_o | output | 4 | Current digit |
| tc_up_n_o | output | 1 | Overflow terminal count, active low |
| tc_dn_n_o | output | 1 | Underflow terminal count, active low |

## Verification
The bench builds two instances with the default of two synchroniser stages, the units digit feeding the tens digit through its terminal-count outputs, so every carry and borrow passes through a second synchroniser and the three-edge latency of R3 applies twice in series. This brings the 99-to-00 and 00-to-99 transitions, the carry that the codes 11, 13 and 15 also produce on their way back into range, and the exact width of the terminal-count pulse within reach of port-level checks.

// File: rtl/decade_cnt_pkg.sv
// Package: shared digit type, step encoding and next-state functions
// for the decade up/down counter. Assumes a 4-bit BCD digit.
package decade_cnt_pkg;

    localparam int DIGIT_W = 4;
    localparam int DIGIT_TOP = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_op_e;

    // Next value when counting up, including the recovery path above 9.
    function automatic digit_t next_up(input digit_t cur);
        digit_t res;
        if (cur == digit_t'(DIGIT_TOP)) begin
            res = '0;
        end else if (cur < digit_t'(DIGIT_TOP)) begin
            res = cur + digit_t'(1);
        end else if (cur[0] == 1'b0) begin
            res = cur + digit_t'(1);
        end else begin
            case (cur)
                4'd11:   res = 4'd6;
                4'd13:   res = 4'd4;
                default: res = 4'd2;
            endcase
        end
        return res;
    endfunction

    // Next value when counting down; codes above 9 simply descend.
    function automatic digit_t next_down(input digit_t cur);
        digit_t res;
        if (cur == '0) begin
            res = digit_t'(DIGIT_TOP);
        end else begin
            res = cur - digit_t'(1);
        end
        return res;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Brings an asynchronous strobe into the clk domain through STAGES flops
// and flags its 0->1 transition for one cycle. Assumes the strobe idles
// high, so reset loads ones and a strobe high at release counts nothing.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic level_o,
    output logic rise_o
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the strobe through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], strobe_i};
        end
    end

    // Synchronised level and its rising transition.
    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    end

    // R3: a single strobe rise yields a one-cycle detect pulse.
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/decade_step.sv
// Module: decade_step
// Combinational next-state selector for one digit: hold, step up or step
// down, using the package functions. Assumes op is one of the enum values.
module decade_step
    import decade_cnt_pkg::*;
(
    input  digit_t   cur_i,
    input  step_op_e op_i,
    output digit_t   nxt_o
);

    // Pick the next digit for the requested step.
    always_comb begin
        case (op_i)
            STEP_UP:   nxt_o = next_up(cur_i);
            STEP_DOWN: nxt_o = next_down(cur_i);
            default:   nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/tc_gen.sv
// Module: tc_gen
// Active-low terminal-count decode. Overflow needs bits 0 and 3 set with
// the up strobe low; underflow needs an all-zero digit with the down
// strobe low. Assumes the strobe levels are already synchronised.
module tc_gen
    import decade_cnt_pkg::*;
(
    input  digit_t q_i,
    input  logic   up_level_i,
    input  logic   dn_level_i,
    output logic   tc_up_n_o,
    output logic   tc_dn_n_o
);

    // Decode both terminal counts from the visible digit.
    always_comb begin
        tc_up_n_o = ~(q_i[0] & q_i[DIGIT_W-1] & ~up_level_i);
        tc_dn_n_o = ~((q_i == '0) & ~dn_level_i);
    end

endmodule

// File: rtl/decade_updn_counter.sv
// Module: decade_updn_counter
// One BCD digit counting on the rising edges of separate up and down
// strobes, with clear above load above counting. Clear and load act on
// q_o combinationally; the stored count follows them at the clock edge.
// Assumes strobes idle high and clk is far faster than strobe activity.
module decade_updn_counter
    import decade_cnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               load_n_i,
    input  logic [DIGIT_W-1:0] data_i,
    input  logic               up_i,
    input  logic               dn_i,
    output logic [DIGIT_W-1:0] q_o,
    output logic               tc_up_n_o,
    output logic               tc_dn_n_o
);

    logic     up_level;
    logic     up_rise;
    logic     dn_level;
    logic     dn_rise;
    step_op_e op;
    digit_t   cnt_q;
    digit_t   cnt_step;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(up_i),
        .level_o (up_level),
        .rise_o  (up_rise)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(dn_i),
        .level_o (dn_level),
        .rise_o  (dn_rise)
    );

    // Step request: one rising strobe with the other strobe idle high.
    always_comb begin
        if (up_rise && dn_level && !dn_rise) begin
            op = STEP_UP;
        end else if (dn_rise && up_level && !up_rise) begin
            op = STEP_DOWN;
        end else begin
            op = STEP_HOLD;
        end
    end

    decade_step u_step (
        .cur_i(cnt_q),
        .op_i (op),
        .nxt_o(cnt_step)
    );

    // Stored count with clear, load and step in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (!load_n_i) begin
            cnt_q <= data_i;
        end else begin
            cnt_q <= cnt_step;
        end
    end

    // Visible digit: clear and load override the stored count at once.
    always_comb begin
        if (clear_i) begin
            q_o = '0;
        end else if (!load_n_i) begin
            q_o = data_i;
        end else begin
            q_o = cnt_q;
        end
    end

    tc_gen u_tc (
        .q_i       (q_o),
        .up_level_i(up_level),
        .dn_level_i(dn_level),
        .tc_up_n_o (tc_up_n_o),
        .tc_dn_n_o (tc_dn_n_o)
    );

    // R1: clear leaves a zero count behind.
    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    // R2: load captures the data input.
    p_load_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_n_i) |=> (cnt_q == $past(data_i)));

    // R3: up step from 9 wraps to 0.
    p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && up_rise && dn_level && !dn_rise && cnt_q == 4'd9)
        |=> (cnt_q == '0));

    // R4: down step from 0 wraps to 9.
    p_dn_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && dn_rise && up_level && !up_rise && cnt_q == '0)
        |=> (cnt_q == 4'd9));

    // R5: up step from 13 recovers to 4.
    p_up_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && up_rise && dn_level && !dn_rise && cnt_q == 4'd13)
        |=> (cnt_q == 4'd4));

    // R6: down step from 10 lands on 9.
    p_dn_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && dn_rise && up_level && !up_rise && cnt_q == 4'd10)
        |=> (cnt_q == 4'd9));

    // R7: simultaneous rises leave the count unchanged.
    p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && up_rise && dn_rise) |=> $stable(cnt_q));

    // R8: overflow output stays high while the up strobe is high.
    p_tc_up_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        up_level |-> tc_up_n_o);

endmodule

// File: tb/decade_updn_counter_tb.sv
module decade_updn_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [1:0] OP_LOAD = 2'd0;
    localparam logic [1:0] OP_UP   = 2'd1;
    localparam logic [1:0] OP_DN   = 2'd2;
    localparam logic [1:0] OP_CLR  = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] du;
        logic [3:0] dt;
        logic [3:0] eu;
        logic [3:0] et;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VECS [NVEC] = '{
        '{OP_LOAD, 4'd8,  4'd0, 4'd8,  4'd0},  // R2
        '{OP_UP,   4'd0,  4'd0, 4'd9,  4'd0},  // R3
        '{OP_UP,   4'd0,  4'd0, 4'd0,  4'd1},  // R10 carry
        '{OP_DN,   4'd0,  4'd0, 4'd9,  4'd0},  // R10 borrow
        '{OP_DN,   4'd0,  4'd0, 4'd8,  4'd0},  // R4
        '{OP_LOAD, 4'd10, 4'd3, 4'd10, 4'd3},  // R2
        '{OP_UP,   4'd0,  4'd0, 4'd11, 4'd3},  // R5
        '{OP_UP,   4'd0,  4'd0, 4'd6,  4'd4},  // R5, carry from 11
        '{OP_UP,   4'd0,  4'd0, 4'd7,  4'd4},  // R3
        '{OP_LOAD, 4'd12, 4'd0, 4'd12, 4'd0},  // R2
        '{OP_UP,   4'd0,  4'd0, 4'd13, 4'd0},  // R5
        '{OP_UP,   4'd0,  4'd0, 4'd4,  4'd1},  // R5, carry from 13
        '{OP_LOAD, 4'd14, 4'd0, 4'd14, 4'd0},  // R2
        '{OP_UP,   4'd0,  4'd0, 4'd15, 4'd0},  // R5
        '{OP_UP,   4'd0,  4'd0, 4'd2,  4'd1},  // R5, carry from 15
        '{OP_LOAD, 4'd15, 4'd5, 4'd15, 4'd5},  // R2
        '{OP_DN,   4'd0,  4'd0, 4'd14, 4'd5},  // R6
        '{OP_DN,   4'd0,  4'd0, 4'd13, 4'd5},  // R6
        '{OP_LOAD, 4'd10, 4'd5, 4'd10, 4'd5},  // R2
        '{OP_DN,   4'd0,  4'd0, 4'd9,  4'd5},  // R6
        '{OP_LOAD, 4'd9,  4'd9, 4'd9,  4'd9},  // R2
        '{OP_UP,   4'd0,  4'd0, 4'd0,  4'd0},  // R10 99 -> 00
        '{OP_DN,   4'd0,  4'd0, 4'd9,  4'd9},  // R10 00 -> 99
        '{OP_CLR,  4'd0,  4'd0, 4'd0,  4'd0}   // R1
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clear;
    logic       load_n;
    logic [3:0] data_u;
    logic [3:0] data_t;
    logic       up_u;
    logic       dn_u;
    logic [3:0] q_u;
    logic [3:0] q_t;
    logic       tcu_u;
    logic       tcd_u;
    logic       tcu_t;
    logic       tcd_t;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decade_updn_counter u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .load_n_i (load_n),
        .data_i   (data_u),
        .up_i     (up_u),
        .dn_i     (dn_u),
        .q_o      (q_u),
        .tc_up_n_o(tcu_u),
        .tc_dn_n_o(tcd_u)
    );

    decade_updn_counter u_tens (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .load_n_i (load_n),
        .data_i   (data_t),
        .up_i     (tcu_u),
        .dn_i     (tcd_u),
        .q_o      (q_t),
        .tc_up_n_o(tcu_t),
        .tc_dn_n_o(tcd_t)
    );

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL R10 watchdog: actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [3:0] u, input logic [3:0] t);
        load_n = 1'b0;
        data_u = u;
        data_t = t;
        wait_neg(2);
        load_n = 1'b1;
        wait_neg(1);
    endtask

    task automatic pulse_up;
        up_u = 1'b0;
        wait_neg(4);
        up_u = 1'b1;
        wait_neg(9);
    endtask

    task automatic pulse_dn;
        dn_u = 1'b0;
        wait_neg(4);
        dn_u = 1'b1;
        wait_neg(9);
    endtask

    initial begin
        int lowcnt;
        rst_n  = 1'b0;
        clear  = 1'b0;
        load_n = 1'b1;
        data_u = '0;
        data_t = '0;
        up_u   = 1'b1;
        dn_u   = 1'b1;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);

        // R11: reset state
        chk("R11 reset units", q_u, 4'd0);
        chk("R11 reset tens", q_t, 4'd0);
        chk("R11 reset tc up", {3'b0, tcu_u}, 4'd1);
        chk("R11 reset tc down", {3'b0, tcd_u}, 4'd1);

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            case (VECS[k].op)
                OP_LOAD: begin do_load(VECS[k].du, VECS[k].dt); tag = "R2 table"; end
                OP_UP:   begin pulse_up(); tag = "R3/R5/R10 table"; end
                OP_DN:   begin pulse_dn(); tag = "R4/R6/R10 table"; end
                default: begin
                    clear = 1'b1;
                    wait_neg(2);
                    clear = 1'b0;
                    wait_neg(1);
                    tag = "R1 table";
                end
            endcase
            chk($sformatf("%s row %0d units", tag, k), q_u, VECS[k].eu);
            chk($sformatf("%s row %0d tens", tag, k), q_t, VECS[k].et);
        end

        // R2: load follows data with no clock edge, strobes ignored
        load_n = 1'b0;
        data_u = 4'd7;
        data_t = 4'd2;
        #1;
        chk("R2 load without edge", q_u, 4'd7);
        wait_neg(1);
        pulse_up();
        load_n = 1'b1;
        wait_neg(1);
        chk("R2 strobe ignored during load", q_u, 4'd7);
        chk("R2 tens after load", q_t, 4'd2);

        // R1: clear overrides load
        clear  = 1'b1;
        load_n = 1'b0;
        data_u = 4'd5;
        #1;
        chk("R1 clear over load", q_u, 4'd0);
        wait_neg(2);
        clear  = 1'b0;
        load_n = 1'b1;
        wait_neg(1);
        chk("R1 stored zero", q_u, 4'd0);

        // R7: both strobes rise together
        do_load(4'd4, 4'd0);
        up_u = 1'b0;
        dn_u = 1'b0;
        wait_neg(4);
        up_u = 1'b1;
        dn_u = 1'b1;
        wait_neg(9);
        chk("R7 simultaneous rise holds", q_u, 4'd4);

        // R7: down strobe rising while up held low
        up_u = 1'b0;
        wait_neg(4);
        pulse_dn();
        chk("R7 down with up low holds", q_u, 4'd4);
        up_u = 1'b1;
        wait_neg(9);
        chk("R3 up rise after hold", q_u, 4'd5);

        // R8: overflow pulse width equals strobe low time
        do_load(4'd9, 4'd0);
        lowcnt = 0;
        up_u = 1'b0;
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            if (!tcu_u) lowcnt++;
            if (i == 6) up_u = 1'b1;
        end
        chk("R8 tc up low cycles", lowcnt[3:0], 4'd6);
        chk("R8 units after overflow", q_u, 4'd0);
        chk("R10 tens after overflow", q_t, 4'd1);

        // R9: underflow output at zero with down strobe low
        dn_u = 1'b0;
        wait_neg(4);
        chk("R9 tc down low", {3'b0, tcd_u}, 4'd0);
        chk("R8 tc up high at zero", {3'b0, tcu_u}, 4'd1);
        dn_u = 1'b1;
        wait_neg(9);
        chk("R9 tc down released", {3'b0, tcd_u}, 4'd1);
        chk("R4 units after underflow", q_u, 4'd9);
        chk("R10 tens after borrow", q_t, 4'd0);

        // R11: synchronous reset mid-run
        do_load(4'd6, 4'd3);
        rst_n = 1'b0;
        wait_neg(1);
        chk("R11 reset clears units", q_u, 4'd0);
        chk("R11 reset clears tens", q_t, 4'd0);
        rst_n = 1'b1;
        wait_neg(4);
        chk("R11 no count after release", q_u, 4'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule